// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block decides, every clock, which of several hardware thread contexts feeds the shared issue stage of a pipeline. It has two policies, chosen at run time.

In interleaved mode it rotates among the eligible threads on every cycle. There is no bubble between threads. Threads that are not ready, or that are blocked on a long-latency event, drop out of the rotation. In switch-on-event mode one thread owns the pipeline until it reports a costly stall. The block then asks for a flush, waits for the pipeline to report empty, and waits a fixed refill time before the new thread may issue.

Either mode can give one thread priority over the others. Per-thread program counters, register files and the datapath sit outside the block. They appear here only as handshake lines.

Top module: `thread_issue_sel`

## Requirements
- R1: In interleaved mode (`modeCur` 0), a thread is granted again on the next cycle only if no other thread is eligible and no preferred thread is set. A thread is eligible when its `threadReady` bit is 1 and its `longStall` bit is 0. Bit i of every per-thread vector belongs to thread i. Switching threads costs no idle cycle.
- R2: The interleaved search begins at the thread after the last granted one, wrapping from N-1 to 0, and skips threads that are not eligible.
- R3: When no thread is eligible in interleaved mode, `issueValid` is 0 and the rotation point does not move.
- R4: With `preferEn` 1, the thread `preferId` is granted whenever it is eligible. This also applies when a new thread is chosen at a switch.
- R5: In switch-on-event mode, the active thread is kept. A short stall (its `threadReady` 0, `longStall` 0) only drops `issueValid` and causes no switch and no flush.
- R6: In switch-on-event mode, a `longStall` on the active thread while another thread is eligible raises `flushReq` for that cycle with `issueValid` 0. The new thread is the first eligible one after the active thread, other than the active thread.
- R7: After a switch, `flushReq` stays 1 until `pipeEmpty` is 1. Then `issueValid` stays 0 for REFILL_CYC further cycles before the new thread issues.
- R8: With `switchOnMemEn` 1, a `memAccess` bit on the active thread is a switch event. With it 0, `memAccess` has no effect.
- R9: If no other thread is eligible when a switch event occurs, the active thread is kept and `flushReq` stays 0.
- R10: A request on `modeCoarse` (1 = switch-on-event) takes effect on the cycle after one where `pipeEmpty` is 1 and no switch is in progress. On entering switch-on-event mode, the thread granted last becomes active. On leaving it, rotation resumes after the active thread.
- R11: After reset the block is in interleaved mode with `issueValid` and `flushReq` at 0, and the first grant goes to thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| threadReady | input | N | Thread has an instruction ready to issue |
| longStall | input | N | Thread is blocked on a costly stall |
| memAccess | input | N | Thread is performing a data memory access |
| switchOnMemEn | input | 1 | Treat memory accesses as switch events |
| modeCoarse | input | 1 | Requested mode: 0 interleaved, 1 switch-on-event |
| preferEn | input | 1 | Enable preferred-thread priority |
| preferId | input | clog2(N) | Preferred thread |
| pipeEmpty | input | 1 | Pipeline holds no in-flight instructions |
| issueTid | output | clog2(N) | Selected thread |
| issueValid | output | 1 | Selected thread issues this cycle |
| flushReq | output | 1 | Request to empty or freeze the pipeline |
| modeCur | output | 1 | Mode in force: 0 interleaved, 1 switch-on-event |

## Verification
The bench builds the block with four threads and a refill time of three cycles. The full drain-and-refill sequence therefore fits in a handful of cycles and can be checked cycle by cycle. Four threads are enough to separate three choices: the round-robin pick after a wrap, a pick that skips a stalled thread, and a preferred pick that differs from the round-robin one.

// File: rtl/tis_pkg.sv
package tis_pkg;

  typedef enum logic [1:0] {
    PH_RUN    = 2'd0,
    PH_DRAIN  = 2'd1,
    PH_REFILL = 2'd2
  } phase_e;

  typedef struct packed {
    logic coarse;     // switch-on-event policy in force
    logic loadGrant;  // capture arbiter winner as last/active thread
  } ctrl_strobe_t;

endpackage

// File: rtl/tis_dpath.sv
module tis_dpath
  import tis_pkg::*;
#(
  parameter int N     = 4,
  parameter int TID_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     threadReady,
  input  logic [N-1:0]     longStall,
  input  logic [N-1:0]     memAccess,
  input  logic             switchOnMemEn,
  input  logic             preferEn,
  input  logic [TID_W-1:0] preferId,
  input  ctrl_strobe_t     strobe,
  output logic [TID_W-1:0] issueTid,
  output logic             grantValid,
  output logic             activeElig,
  output logic             activeEvent
);

  localparam logic [TID_W-1:0] LAST_TID = TID_W'(N - 1);

  logic [TID_W-1:0] lastTid;
  logic [TID_W-1:0] startTid;
  logic [TID_W-1:0] rrTid;
  logic [TID_W-1:0] grantTid;
  logic [N-1:0]     eligible;
  logic [N-1:0]     reqMask;
  logic             rrValid;
  logic             preferHit;

  assign eligible = threadReady & ~longStall;

  // Request mask: in switch-on-event mode the active thread is excluded,
  // since a switch must move to a different context.
  for (genvar t = 0; t < N; t++) begin : g_req
    assign reqMask[t] = eligible[t] & ~(strobe.coarse && (lastTid == TID_W'(t)));
  end

  assign startTid = (lastTid == LAST_TID) ? '0 : lastTid + 1'b1;

  // Rotating priority search, highest priority at startTid.
  always_comb begin
    rrValid = 1'b0;
    rrTid   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int unsigned idx;
      idx = int'(startTid) + k;
      if (idx >= N) idx = idx - N;
      if (reqMask[idx]) begin
        rrValid = 1'b1;
        rrTid   = TID_W'(idx);
      end
    end
  end

  assign preferHit  = preferEn && reqMask[preferId];
  assign grantTid   = preferHit ? preferId : rrTid;
  assign grantValid = rrValid;

  assign activeElig  = eligible[lastTid];
  assign activeEvent = longStall[lastTid] | (switchOnMemEn & memAccess[lastTid]);

  assign issueTid = strobe.coarse ? lastTid : grantTid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastTid <= LAST_TID;
    end else if (strobe.loadGrant) begin
      lastTid <= grantTid;
    end
  end

endmodule

// File: rtl/tis_ctrl.sv
module tis_ctrl
  import tis_pkg::*;
#(
  parameter int REFILL_CYC = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeCoarse,
  input  logic         pipeEmpty,
  input  logic         grantValid,
  input  logic         activeElig,
  input  logic         activeEvent,
  output ctrl_strobe_t strobe,
  output logic         issueValid,
  output logic         flushReq,
  output logic         modeCur
);

  localparam int CNT_W = $clog2(REFILL_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(REFILL_CYC - 1);

  phase_e           phase;
  logic [CNT_W-1:0] refillCnt;
  logic             modeQ;
  logic             switchNow;
  logic             modeLoad;

  always_comb begin
    switchNow        = modeQ && (phase == PH_RUN) && activeEvent && grantValid;
    modeLoad         = (phase == PH_RUN) && !switchNow && pipeEmpty && (modeCoarse != modeQ);
    strobe.coarse    = modeQ;
    strobe.loadGrant = modeQ ? switchNow : grantValid;
    issueValid       = modeQ ? ((phase == PH_RUN) && activeElig && !switchNow) : grantValid;
    flushReq         = switchNow || ((phase == PH_DRAIN) && !pipeEmpty);
  end

  assign modeCur = modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_RUN;
      refillCnt <= '0;
      modeQ     <= 1'b0;
    end else begin
      if (modeLoad) modeQ <= modeCoarse;
      unique case (phase)
        PH_RUN: begin
          if (switchNow) begin
            phase     <= PH_DRAIN;
            refillCnt <= '0;
          end
        end
        PH_DRAIN: begin
          if (pipeEmpty) begin
            phase     <= PH_REFILL;
            refillCnt <= '0;
          end
        end
        PH_REFILL: begin
          if (refillCnt == CNT_END) phase <= PH_RUN;
          else refillCnt <= refillCnt + 1'b1;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel
  import tis_pkg::*;
#(
  parameter int N          = 4,
  parameter int REFILL_CYC = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [N-1:0]         threadReady,
  input  logic [N-1:0]         longStall,
  input  logic [N-1:0]         memAccess,
  input  logic                 switchOnMemEn,
  input  logic                 modeCoarse,
  input  logic                 preferEn,
  input  logic [$clog2(N)-1:0] preferId,
  input  logic                 pipeEmpty,
  output logic [$clog2(N)-1:0] issueTid,
  output logic                 issueValid,
  output logic                 flushReq,
  output logic                 modeCur
);

  localparam int TID_W = $clog2(N);

  ctrl_strobe_t strobe;
  logic         grantValid;
  logic         activeElig;
  logic         activeEvent;

  tis_dpath #(.N(N), .TID_W(TID_W)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .threadReady   (threadReady),
    .longStall     (longStall),
    .memAccess     (memAccess),
    .switchOnMemEn (switchOnMemEn),
    .preferEn      (preferEn),
    .preferId      (preferId),
    .strobe        (strobe),
    .issueTid      (issueTid),
    .grantValid    (grantValid),
    .activeElig    (activeElig),
    .activeEvent   (activeEvent)
  );

  tis_ctrl #(.REFILL_CYC(REFILL_CYC)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeCoarse  (modeCoarse),
    .pipeEmpty   (pipeEmpty),
    .grantValid  (grantValid),
    .activeElig  (activeElig),
    .activeEvent (activeEvent),
    .strobe      (strobe),
    .issueValid  (issueValid),
    .flushReq    (flushReq),
    .modeCur     (modeCur)
  );

endmodule

// File: rtl/tis_checker.sv
module tis_checker #(
  parameter int N = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [N-1:0]         threadReady,
  input logic [N-1:0]         longStall,
  input logic                 preferEn,
  input logic [$clog2(N)-1:0] preferId,
  input logic                 pipeEmpty,
  input logic [$clog2(N)-1:0] issueTid,
  input logic                 issueValid,
  input logic                 flushReq,
  input logic                 modeCur
);

  logic [N-1:0] elig;
  assign elig = threadReady & ~longStall;

  // R1
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeCur && $past(!modeCur) && !preferEn && issueValid && $past(issueValid) &&
     ((elig & ~(N'(1) << $past(issueTid))) != '0))
    |-> (issueTid != $past(issueTid)));

  // R2
  elig_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> elig[issueTid]);

  // R3
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeCur && (elig == '0)) |-> !issueValid);

  // R4
  prefer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeCur && preferEn && elig[preferId]) |-> (issueValid && issueTid == preferId));

  // R5
  hold_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCur && $past(modeCur) && issueValid && $past(issueValid)) |-> $stable(issueTid));

  // R6
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> !issueValid);

  // R10
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCur != $past(modeCur)) |-> $past(pipeEmpty));

  // R1
  fine_noflush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeCur && !$past(modeCur)) |-> !flushReq);

endmodule

bind thread_issue_sel tis_checker #(.N(N)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .threadReady (threadReady),
  .longStall   (longStall),
  .preferEn    (preferEn),
  .preferId    (preferId),
  .pipeEmpty   (pipeEmpty),
  .issueTid    (issueTid),
  .issueValid  (issueValid),
  .flushReq    (flushReq),
  .modeCur     (modeCur)
);

// File: tb/thread_issue_sel_tb.sv
module thread_issue_sel_tb;

  localparam int N      = 4;
  localparam int REFILL = 3;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] threadReady, longStall, memAccess;
  logic       switchOnMemEn, modeCoarse, preferEn, pipeEmpty;
  logic [1:0] preferId;
  logic [1:0] issueTid;
  logic       issueValid, flushReq, modeCur;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 250 MHz

  thread_issue_sel #(.N(N), .REFILL_CYC(REFILL)) u_dut (
    .clk(clk), .rstN(rstN), .threadReady(threadReady), .longStall(longStall),
    .memAccess(memAccess), .switchOnMemEn(switchOnMemEn), .modeCoarse(modeCoarse),
    .preferEn(preferEn), .preferId(preferId), .pipeEmpty(pipeEmpty),
    .issueTid(issueTid), .issueValid(issueValid), .flushReq(flushReq), .modeCur(modeCur)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Check outputs of the current cycle, then advance to the next negedge.
  task automatic expectCyc(string req, bit v, int tid, bit fl, bit checkTid = 1);
    #1;
    chk(req, "issueValid", int'(issueValid), int'(v));
    if (checkTid) chk(req, "issueTid", int'(issueTid), tid);
    chk(req, "flushReq", int'(flushReq), int'(fl));
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    threadReady = '0; longStall = '0; memAccess = '0;
    switchOnMemEn = 0; modeCoarse = 0; preferEn = 0; preferId = '0; pipeEmpty = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Enter switch-on-event mode with thread 0 active.
  task automatic enterCoarse();
    doReset();
    threadReady = 4'hF; modeCoarse = 1; pipeEmpty = 1;
    expectCyc("R10", 1, 0, 0);
    #1 chk("R10", "modeCur", int'(modeCur), 1);
  endtask

  task automatic tReset();
    doReset();
    #1 chk("R11", "modeCur", int'(modeCur), 0);
    expectCyc("R11", 0, 0, 0, 0);
    threadReady = 4'hF;
    expectCyc("R11", 1, 0, 0);
  endtask

  task automatic tRotate();
    doReset();
    threadReady = 4'hF;
    for (int i = 0; i < 6; i++) expectCyc("R1", 1, i % 4, 0);
  endtask

  task automatic tSkip();
    doReset();
    threadReady = 4'b1011;
    expectCyc("R2", 1, 0, 0); expectCyc("R2", 1, 1, 0);
    expectCyc("R2", 1, 3, 0); expectCyc("R2", 1, 0, 0);
    expectCyc("R2", 1, 1, 0);
    threadReady = 4'hF; longStall = 4'b0010;
    expectCyc("R2", 1, 2, 0); expectCyc("R2", 1, 3, 0);
    expectCyc("R2", 1, 0, 0); expectCyc("R2", 1, 2, 0);
  endtask

  task automatic tIdle();
    doReset();
    threadReady = 4'hF;
    expectCyc("R3", 1, 0, 0); expectCyc("R3", 1, 1, 0);
    threadReady = 4'h0;
    expectCyc("R3", 0, 0, 0, 0); expectCyc("R3", 0, 0, 0, 0);
    threadReady = 4'hF;
    expectCyc("R3", 1, 2, 0);
  endtask

  task automatic tPrefer();
    doReset();
    threadReady = 4'hF; preferEn = 1; preferId = 2;
    for (int i = 0; i < 3; i++) expectCyc("R4", 1, 2, 0);
    threadReady = 4'b1011;
    expectCyc("R4", 1, 3, 0); expectCyc("R4", 1, 0, 0);
  endtask

  task automatic tModeDefer();
    doReset();
    threadReady = 4'hF; modeCoarse = 1; pipeEmpty = 0;
    expectCyc("R10", 1, 0, 0); expectCyc("R10", 1, 1, 0);
    #1 chk("R10", "modeCur", int'(modeCur), 0);
    pipeEmpty = 1;
    expectCyc("R10", 1, 2, 0);
    for (int i = 0; i < 3; i++) expectCyc("R10", 1, 2, 0);
  endtask

  task automatic tSwitch();
    enterCoarse();
    expectCyc("R5", 1, 0, 0);
    threadReady = 4'b1110;
    expectCyc("R5", 0, 0, 0); expectCyc("R5", 0, 0, 0);
    threadReady = 4'hF;
    expectCyc("R5", 1, 0, 0);
    longStall = 4'b0001; pipeEmpty = 0;
    expectCyc("R6", 0, 0, 1, 0);
    longStall = '0;
    expectCyc("R7", 0, 1, 1); expectCyc("R7", 0, 1, 1);
    pipeEmpty = 1;
    expectCyc("R7", 0, 1, 0);
    for (int i = 0; i < REFILL; i++) expectCyc("R7", 0, 1, 0);
    expectCyc("R7", 1, 1, 0);
    expectCyc("R5", 1, 1, 0);
  endtask

  task automatic tNoOther();
    enterCoarse();
    threadReady = 4'b0001; longStall = 4'b0001;
    expectCyc("R9", 0, 0, 0); expectCyc("R9", 0, 0, 0);
    threadReady = 4'hF; longStall = '0;
    expectCyc("R9", 1, 0, 0);
  endtask

  task automatic tMemSwitch();
    enterCoarse();
    memAccess = 4'b0001; switchOnMemEn = 0;
    expectCyc("R8", 1, 0, 0); expectCyc("R8", 1, 0, 0);
    switchOnMemEn = 1;
    expectCyc("R8", 0, 0, 1, 0);
    memAccess = '0;
    expectCyc("R8", 0, 1, 0);
    for (int i = 0; i < REFILL; i++) expectCyc("R8", 0, 1, 0);
    expectCyc("R8", 1, 1, 0);
  endtask

  task automatic tPreferSwitchAndBack();
    enterCoarse();
    preferEn = 1; preferId = 2; longStall = 4'b0001;
    expectCyc("R6", 0, 0, 1, 0);
    longStall = '0;
    expectCyc("R4", 0, 2, 0);
    for (int i = 0; i < REFILL; i++) expectCyc("R4", 0, 2, 0);
    expectCyc("R4", 1, 2, 0);
    preferEn = 0; modeCoarse = 0; pipeEmpty = 0;
    expectCyc("R10", 1, 2, 0); expectCyc("R10", 1, 2, 0);
    pipeEmpty = 1;
    expectCyc("R10", 1, 2, 0);
    #1 chk("R10", "modeCur", int'(modeCur), 0);
    expectCyc("R10", 1, 3, 0); expectCyc("R10", 1, 0, 0); expectCyc("R10", 1, 1, 0);
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tRotate();
    tSkip();
    tIdle();
    tPrefer();
    tModeDefer();
    tSwitch();
    tNoOther();
    tMemSwitch();
    tPreferSwitchAndBack();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule